// File: doc/BRIEF.md
# Binary-Method Modular Exponentiation Controller

This block raises an operand to a power modulo an odd modulus, producing `result = operand^exponent mod modulus`. It breaks the exponentiation into a chain of Montgomery modular multiplications. It walks the exponent one bit at a time and drives one or two bit-serial Montgomery multipliers through a start/done handshake. The running result and the base are held in the block's own registers.

A compile-time parameter selects the scan order. The most-significant-first order uses one multiplier. For every exponent bit it issues a square, followed by a multiply only when that bit is set. The least-significant-first order uses two multipliers. Every step squares the base on one unit, and on the same cycles the other unit multiplies the base into the result when the bit is set. This costs roughly one extra multiplier of area in exchange for fewer multiplication rounds.

On an accepted start the block latches the operands. It moves the operand and the value 1 into the Montgomery domain by multiplying each by the supplied constant `R^2 mod modulus`, where `R = 2^WIDTH`. After the last exponent bit it multiplies by 1 to leave that domain, then raises its done flag. The caller must supply an odd modulus greater than 1, an operand smaller than the modulus, and the matching `R^2 mod modulus`.

Top module: `modexp_engine`

## Requirements
- R1: With an odd modulus N (1 < N < 2^WIDTH), an operand C < N and rsq_i = 2^(2*WIDTH) mod N, result_o equals C^E mod N once done_o is high, in both scan orders.
- R2: An exponent of zero yields a result of 1.
- R3: done_o stays high until a start pulse is accepted, and is low in the cycle after an accepted start.
- R4: A start pulse that arrives while an exponentiation is running is ignored: the running operation completes with its original operands.
- R5: In the most-significant-first order, latency grows by the same fixed number of cycles for each set exponent bit. In the least-significant-first order, latency does not depend on the exponent value.
- R6: For the same operands, the least-significant-first order finishes in fewer cycles than the most-significant-first order.
- R7: Every product a multiplier returns is already reduced below the modulus, so result_o < N.
- R8: After reset, done_o is low and result_o is zero.
- R9: result_o keeps the previous result while a new exponentiation runs, and changes only when the new result is ready.
- R10: All WIDTH exponent bits are processed, including an exponent with only bit 0 set and one with only bit WIDTH-1 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request to begin; accepted only when idle or done |
| operand_i | input | WIDTH | Base C, must be below the modulus |
| exponent_i | input | WIDTH | Exponent E |
| modulus_i | input | WIDTH | Odd modulus N greater than 1 |
| rsq_i | input | WIDTH | Precomputed 2^(2*WIDTH) mod N |
| done_o | output | 1 | High from completion until the next accepted start |
| result_o | output | WIDTH | C^E mod N, valid while done_o is high |

## Verification
The bench builds two copies of the block at WIDTH = 16, one for each scan order, and drives them with the same stimulus. This width lets the bench compute every expected power with 64-bit arithmetic. It also keeps a full exponentiation to a few hundred cycles, so all-ones, single-bit and zero exponents fit in the run alongside mid-run start pulses. Running both orders side by side makes the latency relations directly measurable: the per-set-bit cost of the serial order, the exponent-independence of the parallel order, and the gap between them.

// File: rtl/modexp_pkg.sv
package modexp_pkg;

  typedef enum logic {
    SCAN_MSB_FIRST = 1'b0,
    SCAN_LSB_FIRST = 1'b1
  } scan_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_BASE = 3'd1,
    PH_ONE  = 3'd2,
    PH_SQR  = 3'd3,
    PH_MUL  = 3'd4,
    PH_OUT  = 3'd5,
    PH_DONE = 3'd6
  } phase_e;

endpackage

// File: rtl/modexp_montmul.sv
module modexp_montmul #(
  parameter int WIDTH = 1024
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] n_i,
  output logic             done_o,
  output logic [WIDTH-1:0] p_o
);

  localparam int ACC_W = WIDTH + 2;
  localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  logic             run_q, run_d;
  logic             fix_q, fix_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [WIDTH-1:0] a_q, b_q, n_q, p_q;
  logic [WIDTH-1:0] p_d;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W-1:0] sum_add, sum_red, acc_fix;
  logic             p_en;

  // one radix-2 step: add b when the current a bit is set, add n to make it even, halve
  always_comb begin
    sum_add = acc_q + (a_q[0] ? {2'b00, b_q} : '0);
    sum_red = sum_add[0] ? (sum_add + {2'b00, n_q}) : sum_add;
    acc_fix = (acc_q >= {2'b00, n_q}) ? (acc_q - {2'b00, n_q}) : acc_q;
  end

  always_comb begin
    run_d  = run_q;
    fix_d  = 1'b0;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    p_d    = p_q;
    p_en   = 1'b0;
    if (start_i && !run_q && !fix_q) begin
      run_d = 1'b1;
      cnt_d = '0;
      acc_d = '0;
    end else if (run_q) begin
      acc_d = sum_red >> 1;
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        run_d = 1'b0;
        fix_d = 1'b1;
      end
    end else if (fix_q) begin
      p_d    = acc_fix[WIDTH-1:0];
      p_en   = 1'b1;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      fix_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      acc_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
      n_q    <= '0;
      p_q    <= '0;
    end else begin
      run_q  <= run_d;
      fix_q  <= fix_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      acc_q  <= acc_d;
      if (start_i && !run_q && !fix_q) begin
        a_q <= a_i;
        b_q <= b_i;
        n_q <= n_i;
      end else if (run_q) begin
        a_q <= a_q >> 1;
      end
      if (p_en) begin
        p_q <= p_d;
      end
    end
  end

  assign done_o = done_q;
  assign p_o    = p_q;

  AST_PRODUCT_REDUCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (p_q < n_q)); // R7

  AST_NO_RESTART_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q || fix_q) |-> !start_i); // R4

endmodule

// File: rtl/modexp_ctrl.sv
module modexp_ctrl
  import modexp_pkg::*;
#(
  parameter int    WIDTH = 1024,
  parameter scan_e SCAN  = SCAN_MSB_FIRST
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] c_i,
  input  logic [WIDTH-1:0] e_i,
  input  logic [WIDTH-1:0] n_i,
  input  logic [WIDTH-1:0] rsq_i,
  output logic [WIDTH-1:0] n_o,
  output logic             m0_start_o,
  output logic [WIDTH-1:0] m0_a_o,
  output logic [WIDTH-1:0] m0_b_o,
  input  logic             m0_done_i,
  input  logic [WIDTH-1:0] m0_p_i,
  output logic             m1_start_o,
  output logic [WIDTH-1:0] m1_a_o,
  output logic [WIDTH-1:0] m1_b_o,
  input  logic             m1_done_i,
  input  logic [WIDTH-1:0] m1_p_i,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o
);

  localparam bit LSB_FIRST = (SCAN == SCAN_LSB_FIRST);
  localparam int CNT_W     = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WIDTH - 1);
  localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

  phase_e           st_q, st_d;
  logic             wait_q, wait_d;
  logic             m1_pend_q, m1_pend_d;
  logic [CNT_W-1:0] bit_cnt_q, bit_cnt_d;
  logic [WIDTH-1:0] c_q, n_q, rsq_q;
  logic [WIDTH-1:0] e_q, e_d;
  logic [WIDTH-1:0] res_q, res_d;
  logic [WIDTH-1:0] base_q, base_d;
  logic [WIDTH-1:0] out_q, out_d;
  logic             out_en;
  logic             accept, active, finish, step, cur_bit, launch;

  assign cur_bit = LSB_FIRST ? e_q[0] : e_q[WIDTH-1];
  assign active  = (st_q != PH_IDLE) && (st_q != PH_DONE);
  assign accept  = !active && start_i;
  assign launch  = active && !wait_q;
  assign finish  = wait_q && m0_done_i && (!m1_pend_q || m1_done_i);

  // operand routing to the multipliers
  always_comb begin
    m0_start_o = launch;
    m0_a_o     = '0;
    m0_b_o     = '0;
    m1_start_o = 1'b0;
    m1_a_o     = '0;
    m1_b_o     = '0;
    case (st_q)
      PH_BASE: begin
        m0_a_o = c_q;
        m0_b_o = rsq_q;
        if (LSB_FIRST) begin
          m1_start_o = launch;
          m1_a_o     = ONE;
          m1_b_o     = rsq_q;
        end
      end
      PH_ONE: begin
        m0_a_o = ONE;
        m0_b_o = rsq_q;
      end
      PH_SQR: begin
        if (LSB_FIRST) begin
          m0_a_o     = base_q;
          m0_b_o     = base_q;
          m1_start_o = launch && cur_bit;
          m1_a_o     = res_q;
          m1_b_o     = base_q;
        end else begin
          m0_a_o = res_q;
          m0_b_o = res_q;
        end
      end
      PH_MUL: begin
        m0_a_o = res_q;
        m0_b_o = base_q;
      end
      PH_OUT: begin
        m0_a_o = res_q;
        m0_b_o = ONE;
      end
      default: ;
    endcase
  end

  // next-state logic
  always_comb begin
    st_d      = st_q;
    wait_d    = wait_q;
    m1_pend_d = m1_pend_q;
    bit_cnt_d = bit_cnt_q;
    e_d       = e_q;
    res_d     = res_q;
    base_d    = base_q;
    out_d     = out_q;
    out_en    = 1'b0;
    step      = 1'b0;
    if (launch) begin
      wait_d    = 1'b1;
      m1_pend_d = m1_start_o;
    end
    case (st_q)
      PH_IDLE, PH_DONE: begin
        if (start_i) begin
          st_d      = PH_BASE;
          wait_d    = 1'b0;
          m1_pend_d = 1'b0;
          bit_cnt_d = '0;
          e_d       = e_i;
        end
      end
      PH_BASE: begin
        if (finish) begin
          wait_d = 1'b0;
          base_d = m0_p_i;
          if (LSB_FIRST) begin
            res_d = m1_p_i;
            st_d  = PH_SQR;
          end else begin
            st_d = PH_ONE;
          end
        end
      end
      PH_ONE: begin
        if (finish) begin
          wait_d = 1'b0;
          res_d  = m0_p_i;
          st_d   = PH_SQR;
        end
      end
      PH_SQR: begin
        if (finish) begin
          wait_d = 1'b0;
          if (LSB_FIRST) begin
            base_d = m0_p_i;
            if (cur_bit) begin
              res_d = m1_p_i;
            end
            step = 1'b1;
          end else begin
            res_d = m0_p_i;
            if (cur_bit) begin
              st_d = PH_MUL;
            end else begin
              step = 1'b1;
            end
          end
        end
      end
      PH_MUL: begin
        if (finish) begin
          wait_d = 1'b0;
          res_d  = m0_p_i;
          step   = 1'b1;
        end
      end
      PH_OUT: begin
        if (finish) begin
          wait_d = 1'b0;
          out_d  = m0_p_i;
          out_en = 1'b1;
          st_d   = PH_DONE;
        end
      end
      default: st_d = PH_IDLE;
    endcase
    if (step) begin
      e_d       = LSB_FIRST ? (e_q >> 1) : (e_q << 1);
      bit_cnt_d = bit_cnt_q + 1'b1;
      st_d      = (bit_cnt_q == LAST_BIT) ? PH_OUT : PH_SQR;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= PH_IDLE;
      wait_q    <= 1'b0;
      m1_pend_q <= 1'b0;
      bit_cnt_q <= '0;
      e_q       <= '0;
      res_q     <= '0;
      base_q    <= '0;
      out_q     <= '0;
      c_q       <= '0;
      n_q       <= '0;
      rsq_q     <= '0;
    end else begin
      st_q      <= st_d;
      wait_q    <= wait_d;
      m1_pend_q <= m1_pend_d;
      bit_cnt_q <= bit_cnt_d;
      e_q       <= e_d;
      res_q     <= res_d;
      base_q    <= base_d;
      if (out_en) begin
        out_q <= out_d;
      end
      if (accept) begin
        c_q   <= c_i;
        n_q   <= n_i;
        rsq_q <= rsq_i;
      end
    end
  end

  assign n_o      = n_q;
  assign done_o   = (st_q == PH_DONE);
  assign result_o = out_q;

  AST_DONE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o); // R3

  AST_START_CLEARS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> !done_o); // R3

  AST_BUSY_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && start_i) |=> ($stable(c_q) && $stable(n_q) && $stable(rsq_q))); // R4

  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(st_q == PH_OUT && finish) |=> $stable(out_q)); // R9

  AST_UNITS_LOCKSTEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m1_done_i |-> m0_done_i); // R6

  AST_RESULT_BELOW_MODULUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (out_q < n_q)); // R7

endmodule

// File: rtl/modexp_engine.sv
module modexp_engine
  import modexp_pkg::*;
#(
  parameter int    WIDTH = 1024,
  parameter scan_e SCAN  = SCAN_MSB_FIRST
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] operand_i,
  input  logic [WIDTH-1:0] exponent_i,
  input  logic [WIDTH-1:0] modulus_i,
  input  logic [WIDTH-1:0] rsq_i,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o
);

  logic [1:0]       rst_sync_q;
  logic             rst_n;
  logic [WIDTH-1:0] n_lat;
  logic             m0_start, m0_done, m1_start, m1_done;
  logic [WIDTH-1:0] m0_a, m0_b, m0_p, m1_a, m1_b, m1_p;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[1];

  modexp_ctrl #(
    .WIDTH (WIDTH),
    .SCAN  (SCAN)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .start_i    (start_i),
    .c_i        (operand_i),
    .e_i        (exponent_i),
    .n_i        (modulus_i),
    .rsq_i      (rsq_i),
    .n_o        (n_lat),
    .m0_start_o (m0_start),
    .m0_a_o     (m0_a),
    .m0_b_o     (m0_b),
    .m0_done_i  (m0_done),
    .m0_p_i     (m0_p),
    .m1_start_o (m1_start),
    .m1_a_o     (m1_a),
    .m1_b_o     (m1_b),
    .m1_done_i  (m1_done),
    .m1_p_i     (m1_p),
    .done_o     (done_o),
    .result_o   (result_o)
  );

  modexp_montmul #(
    .WIDTH (WIDTH)
  ) u_mul_sq (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .start_i (m0_start),
    .a_i     (m0_a),
    .b_i     (m0_b),
    .n_i     (n_lat),
    .done_o  (m0_done),
    .p_o     (m0_p)
  );

  generate
    if (SCAN == SCAN_LSB_FIRST) begin : g_dual
      modexp_montmul #(
        .WIDTH (WIDTH)
      ) u_mul_acc (
        .clk_i   (clk_i),
        .rst_ni  (rst_n),
        .start_i (m1_start),
        .a_i     (m1_a),
        .b_i     (m1_b),
        .n_i     (n_lat),
        .done_o  (m1_done),
        .p_o     (m1_p)
      );
    end else begin : g_single
      logic unused_m1;
      assign unused_m1 = ^{m1_start, m1_a, m1_b};
      assign m1_done   = 1'b0;
      assign m1_p      = '0;
    end
  endgenerate

endmodule

// File: tb/modexp_engine_tb_top.sv
`timescale 1ns/1ps
module modexp_engine_tb_top;
  import modexp_pkg::*;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] op_c = '0, op_e = '0, op_n = '0, op_r2 = '0;
  logic         done_l, done_r;
  logic [W-1:0] res_l, res_r;

  int checks = 0;
  int fails  = 0;
  int cyc_l, cyc_r;

  always #10 clk = ~clk;

  modexp_engine #(.WIDTH(W), .SCAN(SCAN_MSB_FIRST)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .operand_i(op_c),
    .exponent_i(op_e), .modulus_i(op_n), .rsq_i(op_r2),
    .done_o(done_l), .result_o(res_l));

  modexp_engine #(.WIDTH(W), .SCAN(SCAN_LSB_FIRST)) dut_r_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .operand_i(op_c),
    .exponent_i(op_e), .modulus_i(op_n), .rsq_i(op_r2),
    .done_o(done_r), .result_o(res_r));

  function automatic longint unsigned ref_pow(longint unsigned b, longint unsigned e,
                                              longint unsigned m);
    longint unsigned r = 1 % m;
    b = b % m;
    for (int i = 0; i < W; i++) begin
      if ((e >> i) & 1) r = (r * b) % m;
      b = (b * b) % m;
    end
    return r;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic launch(input logic [W-1:0] c, input logic [W-1:0] e, input logic [W-1:0] n);
    longint unsigned r2;
    r2 = (64'd1 << (2 * W)) % n;
    @(negedge clk);
    op_c  = c;
    op_e  = e;
    op_n  = n;
    op_r2 = r2[W-1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_both();
    bit dl = 0, dr = 0;
    int n_cyc = 1;
    while (!(dl && dr)) begin
      if (done_l && !dl) begin dl = 1; cyc_l = n_cyc; end
      if (done_r && !dr) begin dr = 1; cyc_r = n_cyc; end
      if (!(dl && dr)) begin
        @(negedge clk);
        n_cyc++;
      end
    end
  endtask

  task automatic run_and_check(input string req, input logic [W-1:0] c,
                               input logic [W-1:0] e, input logic [W-1:0] n);
    longint unsigned exp_v;
    exp_v = ref_pow(c, e, n);
    launch(c, e, n);
    wait_both();
    check({req, " msb-first result"}, res_l, exp_v);
    check({req, " lsb-first result"}, res_r, exp_v);
    check("R7 result below modulus", (res_l < n) && (res_r < n), 1);
  endtask

  task automatic t_reset();
    check("R8 done low after reset (msb)", done_l, 0);
    check("R8 done low after reset (lsb)", done_r, 0);
    check("R8 result zero after reset", res_l | res_r, 0);
  endtask

  task automatic t_main();
    run_and_check("R1 mixed exponent", 16'h1234, 16'h5A3C, 16'hF1C9);
    run_and_check("R1 all-ones exponent", 16'h7FFF, 16'hFFFF, 16'h8003);
    run_and_check("R1 small modulus", 16'd12, 16'hFFFF, 16'd13);
    run_and_check("R1 full-range modulus", 16'hABCD, 16'h0F0F, 16'hFFFF);
    run_and_check("R10 only bit 0 set", 16'h2468, 16'h0001, 16'hF1C9);
    run_and_check("R10 only top bit set", 16'h2468, 16'h8000, 16'hF1C9);
  endtask

  task automatic t_zero_exp();
    launch(16'h1357, 16'h0000, 16'hF1C9);
    wait_both();
    check("R2 zero exponent (msb)", res_l, 1);
    check("R2 zero exponent (lsb)", res_r, 1);
    launch(16'd2, 16'h0000, 16'd3);
    wait_both();
    check("R2 zero exponent, modulus 3", res_l + res_r, 2);
  endtask

  task automatic t_done_hold();
    logic [W-1:0] prev;
    longint unsigned exp_v;
    launch(16'h0777, 16'h0123, 16'hF1C9);
    wait_both();
    prev = res_l;
    repeat (25) @(negedge clk);
    check("R3 done still high (msb)", done_l, 1);
    check("R3 done still high (lsb)", done_r, 1);
    check("R3 result steady while done", res_l, prev);
    exp_v = ref_pow(16'h0999, 16'h0321, 16'hF1C9);
    launch(16'h0999, 16'h0321, 16'hF1C9);
    check("R3 done low after accepted start", done_l | done_r, 0);
    repeat (5) @(negedge clk);
    check("R9 old result held during run (msb)", res_l, prev);
    check("R9 old result held during run (lsb)", res_r, prev);
    wait_both();
    check("R9 new result after finish", res_l, exp_v);
  endtask

  task automatic t_busy_ignore();
    longint unsigned exp_a;
    exp_a = ref_pow(16'h0ABC, 16'hC0DE, 16'hF1C9);
    launch(16'h0ABC, 16'hC0DE, 16'hF1C9);
    repeat (40) @(negedge clk);
    op_c  = 16'h0001;
    op_e  = 16'h0002;
    op_n  = 16'h0007;
    op_r2 = 16'h0002;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_both();
    check("R4 busy start ignored (msb)", res_l, exp_a);
    check("R4 busy start ignored (lsb)", res_r, exp_a);
    repeat (400) @(negedge clk);
    check("R4 no second run after ignored start", done_l && done_r && res_l == exp_a, 1);
  endtask

  task automatic t_latency();
    int l0, l1, lf, r0, r1, rf;
    launch(16'h0055, 16'h0000, 16'hF1C9); wait_both(); l0 = cyc_l; r0 = cyc_r;
    launch(16'h0055, 16'h0001, 16'hF1C9); wait_both(); l1 = cyc_l; r1 = cyc_r;
    launch(16'h0055, 16'hFFFF, 16'hF1C9); wait_both(); lf = cyc_l; rf = cyc_r;
    check("R5 msb-first grows per set bit", lf - l0, 16 * (l1 - l0));
    check("R5 msb-first set bit costs cycles", l1 > l0, 1);
    check("R5 lsb-first latency fixed (one bit)", r1, r0);
    check("R5 lsb-first latency fixed (all bits)", rf, r0);
    check("R6 lsb-first faster, zero exponent", r0 < l0, 1);
    check("R6 lsb-first faster, all-ones exponent", rf < lf, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_main();
    t_zero_exp();
    t_done_hold();
    t_busy_ignore();
    t_latency();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule